// File: doc/BRIEF.md
# SMBus Line Condition Monitor

This block watches the clock and data wires of a two-wire SMBus segment with a fast system clock. It passes each wire through a resynchroniser and a stability filter. It then reports three kinds of event as single-cycle pulses: bus start conditions, bus stop conditions and data-sample points. Each data-sample point is a rising edge of the filtered clock wire. A serial slave engine that assembles bytes and decodes commands uses these pulses, and that engine sits outside this block.

The block also guards against a clock wire that is held low. A counter runs while the filtered clock is low and clears whenever the clock is seen high. When the count reaches a threshold, the block emits a timeout pulse that returns the slave to idle. The threshold is a parameter in system-clock cycles. It should be chosen so that the time lies between the shortest period that must leave the slave untouched and the longest period after which the slave must give up. At 50 MHz, the default of 1,500,000 cycles gives 30 ms. A busy flag is set by a start and cleared by a stop or a timeout.

Top module: `smb_bus_monitor`

## Requirements
- R1: While reset is high, and after it is released with both wires high, every output is 0 and no pulse occurs.
- R2: A falling data wire while the clock wire is high gives exactly one start pulse of one cycle and sets the busy flag.
- R3: A rising data wire while the clock wire is high gives exactly one stop pulse of one cycle and clears the busy flag.
- R4: Data-wire changes made while the clock wire is low give neither a start nor a stop pulse.
- R5: Each rising edge of the clock wire gives exactly one sample strobe of one cycle. A falling clock edge gives none.
- R6: A pulse on either wire that lasts fewer than FILT_LEN system cycles is ignored and produces no output pulse.
- R7: A clock wire held low for at least TIMEOUT_CYC system cycles gives exactly one timeout pulse per low period and clears the busy flag.
- R8: A clock wire held low for fewer than TIMEOUT_CYC cycles gives no timeout and leaves the busy flag unchanged.
- R9: The low-time count restarts whenever the clock wire is seen high. Two short low periods separated by a high level therefore never add up to a timeout.
- R10: At most one of start, stop and timeout is high in any cycle. If a start and a timeout would coincide, only the timeout is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| start_o | output | 1 | One-cycle start condition pulse |
| stop_o | output | 1 | One-cycle stop condition pulse |
| timeout_o | output | 1 | One-cycle clock-low timeout pulse |
| sample_o | output | 1 | One-cycle strobe on each clock rising edge |
| busy_o | output | 1 | High from a start until a stop or timeout |

## Verification
The bench mixes random transfers with directed cases. In the random transfers, the data wire toggles only during clock-low time. A detector that ignores the clock level would count false starts and stops in these transfers, and one that samples on both clock edges would count too many strobes. The directed cases cover:
- one- and two-cycle glitches on each wire, which a filter that is too short would turn into spurious conditions;
- a low clock held well past the threshold, which must give one timeout and not a train of them, and must clear busy;
- single and split low periods below the threshold, which a counter that never restarts would turn into a false timeout.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic strobe;
    } bus_cond_t;

    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_FILT_LEN    = 3;
    localparam int unsigned DEF_TIMEOUT_CYC = 1_500_000;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = smb_mon_pkg::cnt_width(LEN);

    logic [STAGES-1:0] sync_q;
    logic [CW-1:0]     cnt_q;
    logic              filt_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], line_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_q[STAGES-1] != filt_q) begin
            if (cnt_q == CW'(LEN - 1)) begin
                filt_q <= sync_q[STAGES-1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign line_o = filt_q;

    assert_filter_follows_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> ($past(sync_q[STAGES-1]) == filt_q));
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
    input  logic                    clk,
    input  logic                    rst,
    input  smb_mon_pkg::bus_lines_t lines_i,
    output smb_mon_pkg::bus_cond_t  cond_o
);
    import smb_mon_pkg::*;

    bus_lines_t prev_q;
    bus_cond_t  cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
            cond_q <= '0;
        end else begin
            prev_q        <= lines_i;
            cond_q.start  <= lines_i.scl & prev_q.scl & prev_q.sda & ~lines_i.sda;
            cond_q.stop   <= lines_i.scl & prev_q.scl & ~prev_q.sda & lines_i.sda;
            cond_q.strobe <= lines_i.scl & ~prev_q.scl;
        end
    end

    assign cond_o = cond_q;

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        cond_q.strobe |=> !cond_q.strobe);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        cond_q.start |=> !cond_q.start);
    assert_stop_single_R3: assert property (@(posedge clk) disable iff (rst)
        cond_q.stop |=> !cond_q.stop);
    assert_start_scl_high_R4: assert property (@(posedge clk) disable iff (rst)
        cond_q.start |-> $past(lines_i.scl));
endmodule

// File: rtl/smb_low_watchdog.sv
module smb_low_watchdog #(
    parameter int unsigned LIMIT = 1_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    output logic timeout_o
);
    localparam int unsigned CW = smb_mon_pkg::cnt_width(LIMIT);

    logic [CW-1:0] low_cnt_q;
    logic          to_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt_q <= '0;
            to_q      <= 1'b0;
        end else begin
            to_q <= ~scl_i && (low_cnt_q == CW'(LIMIT - 1));
            if (scl_i)                      low_cnt_q <= '0;
            else if (low_cnt_q != CW'(LIMIT)) low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign timeout_o = to_q;

    assert_timeout_single_R7: assert property (@(posedge clk) disable iff (rst)
        to_q |=> !to_q);
    assert_timeout_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        to_q |-> !$past(scl_i));
endmodule

// File: rtl/smb_bus_monitor.sv
module smb_bus_monitor #(
    parameter int unsigned SYNC_STAGES = smb_mon_pkg::DEF_SYNC_STAGES,
    parameter int unsigned FILT_LEN    = smb_mon_pkg::DEF_FILT_LEN,
    parameter int unsigned TIMEOUT_CYC = smb_mon_pkg::DEF_TIMEOUT_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic timeout_o,
    output logic sample_o,
    output logic busy_o
);
    import smb_mon_pkg::*;

    localparam int unsigned NLINES = $bits(bus_lines_t);

    logic [NLINES-1:0] raw_vec;
    logic [NLINES-1:0] filt_vec;
    bus_lines_t        filt;
    bus_cond_t         cond;
    logic              to_pulse;
    logic              busy_q;

    assign raw_vec = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        smb_line_filter #(.STAGES(SYNC_STAGES), .LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw_vec[g]),
            .line_o (filt_vec[g])
        );
    end

    assign filt = bus_lines_t'(filt_vec);

    smb_cond_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .lines_i (filt),
        .cond_o  (cond)
    );

    smb_low_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (filt.scl),
        .timeout_o (to_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)                         busy_q <= 1'b0;
        else if (to_pulse || cond.stop) busy_q <= 1'b0;
        else if (cond.start)             busy_q <= 1'b1;
    end

    assign start_o   = cond.start & ~to_pulse;
    assign stop_o    = cond.stop & ~to_pulse;
    assign timeout_o = to_pulse;
    assign sample_o  = cond.strobe;
    assign busy_o    = busy_q;

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, stop_o, timeout_o}));
    assert_busy_clear_R7: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !busy_o);
    assert_busy_set_R2: assert property (@(posedge clk) disable iff (rst)
        start_o |=> busy_o);
    assert_busy_drop_R3: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> !busy_o);
endmodule

// File: tb/sim_smb_bus_monitor.sv
module sim_smb_bus_monitor;
    localparam int unsigned FL = 3;
    localparam int unsigned TO = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic start_o, stop_o, timeout_o, sample_o, busy_o;

    int n_chk = 0;
    int n_bad = 0;
    int c_start = 0, c_stop = 0, c_to = 0, c_smp = 0;
    int s_start, s_stop, s_to, s_smp;
    bit rep_on = 1'b0;

    always #10 clk = ~clk;

    smb_bus_monitor #(.SYNC_STAGES(2), .FILT_LEN(FL), .TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .start_o(start_o), .stop_o(stop_o), .timeout_o(timeout_o),
        .sample_o(sample_o), .busy_o(busy_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            c_start += int'(start_o);
            c_stop  += int'(stop_o);
            c_to    += int'(timeout_o);
            c_smp   += int'(sample_o);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap();
        s_start = c_start; s_stop = c_stop; s_to = c_to; s_smp = c_smp;
    endtask

    function automatic int exp_strobes(input int nbytes);
        return nbytes * 9 + 1;
    endfunction

    function automatic int rnd_len();
        return 6 + int'($urandom_range(14));
    endfunction

    task automatic do_start();
        sda = 1'b1; wait_cyc(rnd_len());
        scl = 1'b1; wait_cyc(rnd_len());
        sda = 1'b0; wait_cyc(rnd_len());
        scl = 1'b0; wait_cyc(rnd_len());
    endtask

    task automatic do_bit(input logic b);
        wait_cyc(rnd_len());
        sda = b;    wait_cyc(rnd_len());
        scl = 1'b1; wait_cyc(rnd_len());
        scl = 1'b0;
    endtask

    task automatic do_stop();
        wait_cyc(rnd_len());
        sda = 1'b0; wait_cyc(rnd_len());
        scl = 1'b1; wait_cyc(rnd_len());
        sda = 1'b1; wait_cyc(rnd_len() + 8);
    endtask

    initial begin
        process::self().srandom(32'd4711);
        wait_cyc(5);
        chk("R1 start in reset", int'(start_o), 0);
        chk("R1 busy in reset", int'(busy_o), 0);
        rst = 1'b0;
        snap();
        wait_cyc(30);
        chk("R1 no pulses after reset", c_start + c_stop + c_to + c_smp - s_start - s_stop - s_to - s_smp, 0);
        chk("R1 busy idle", int'(busy_o), 0);

        // R6: short glitches on each wire while idle
        snap();
        sda = 1'b0; wait_cyc(1); sda = 1'b1; wait_cyc(15);
        sda = 1'b0; wait_cyc(FL - 1); sda = 1'b1; wait_cyc(15);
        scl = 1'b0; wait_cyc(FL - 1); scl = 1'b1; wait_cyc(15);
        chk("R6 sda glitch no start", c_start - s_start, 0);
        chk("R6 scl glitch no strobe", c_smp - s_smp, 0);
        chk("R6 busy unchanged", int'(busy_o), 0);

        // R2..R5: random transfers with data toggling during clock-low time
        for (int t = 0; t < 20; t++) begin
            int nb;
            nb = 1 + int'($urandom_range(2));
            snap();
            do_start();
            chk("R2 busy after start", int'(busy_o), 1);
            for (int i = 0; i < nb * 9; i++) do_bit(logic'($urandom_range(1)));
            chk("R4 no stop during data", c_stop - s_stop, 0);
            do_stop();
            chk("R2 one start", c_start - s_start, 1);
            chk("R3 one stop", c_stop - s_stop, 1);
            chk("R5 strobes", c_smp - s_smp, exp_strobes(nb));
            chk("R3 busy cleared", int'(busy_o), 0);
            chk("R4 no timeout in transfer", c_to - s_to, 0);
        end

        // R6: glitch on SCL inside a transfer, while low
        snap();
        do_start();
        scl = 1'b1; wait_cyc(1); scl = 1'b0; wait_cyc(12);
        chk("R6 scl low glitch no strobe", c_smp - s_smp, 0);

        // R8: low below threshold keeps busy
        wait_cyc(TO / 2);
        chk("R8 no timeout short low", c_to - s_to, 0);
        chk("R8 busy kept", int'(busy_o), 1);

        // R9: split low periods
        scl = 1'b1; wait_cyc(12); scl = 1'b0;
        wait_cyc(TO * 7 / 10);
        chk("R9 split lows no timeout", c_to - s_to, 0);
        chk("R9 busy kept", int'(busy_o), 1);

        // R7: long low
        wait_cyc(TO * 2);
        chk("R7 one timeout", c_to - s_to, 1);
        chk("R7 busy cleared", int'(busy_o), 0);
        chk("R10 no start on timeout", c_start - s_start, 1);
        sda = 1'b1; wait_cyc(10);
        scl = 1'b1; wait_cyc(20);
        chk("R7 no stop on release", c_stop - s_stop, 0);

        // R2: new start accepted after timeout recovery
        snap();
        do_start();
        chk("R2 start after timeout", c_start - s_start, 1);
        do_bit(1'b0);
        do_stop();
        chk("R3 stop after recovery", c_stop - s_stop, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule